// File: doc/BRIEF.md
# Plus-Minus Modular Divider over a Prime Field

This block computes z = x · y⁻¹ mod p for an odd prime p of up to K bits. It runs the plus-minus form of the binary GCD. Each step decides what to do from the two low bits of its operands and from a pair of logarithmic size bounds. It never compares the magnitudes of the two running values, so the longest path in one step is an adder, a correction adder and a shift.

A caller presents x, y and p, with 0 ≤ x < p and 0 < y < p, and pulses `start_i` for one cycle. The block then performs one reduction step per clock. `done_o` rises when the result is ready and stays high, with `z_o` held, until the next accepted start. Any p below 2^K works: a small prime is passed with its upper bits at zero.

Top module: `pm_moddiv`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `z_o` is 0 until a computation finishes.
- R2: A `start_i` pulse sampled while the block is idle or finished loads the operands, and `done_o` reads 0 from the next clock edge onwards.
- R3: When `done_o` is 1, `z_o` is below p and (z_o · y) mod p equals x. This holds for every odd prime p < 2^K, 0 ≤ x < p and 0 < y < p.
- R4: `done_o` rises no later than 2K+1 clock edges after the edge that samples `start_i`.
- R5: A `start_i` pulse that arrives while a computation is running is ignored, and the running computation finishes with the result for its own operands.
- R6: Special operands give exact values: y = 1 gives z = x, y = p−1 gives z = (p−x) mod p, and x = 0 gives z = 0.
- R7: Once `done_o` is 1, it stays 1 and `z_o` does not change until the next accepted `start_i`.
- R8: Full-width primes close to 2^K, such as 2^192 − 2^64 − 1 with K = 192, give results that meet R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a division |
| x_i | input | K | Dividend, below p |
| y_i | input | K | Divisor, nonzero and below p |
| p_i | input | K | Odd prime modulus |
| z_o | output | K | Quotient x·y⁻¹ mod p |
| done_o | output | 1 | Result valid, held until the next start |

## Verification
The edge that samples `start_i` loads the operands. Each following edge performs one reduction step. A final edge, which sees the running value at zero, writes `z_o` and sets `done_o`, so a result is due at most 2K+1 edges after the start edge.

The bench drives inputs and samples outputs on falling edges. It checks that `done_o` is already low at the first falling edge after the start. It then counts falling edges until `done_o` appears and compares that count against the 2K+1 bound. `z_o` is judged only once `done_o` has been seen, and it is sampled again ten cycles later to confirm that it holds.

// File: rtl/pmdiv_pkg.sv
package pmdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } pmdiv_state_e;

  // Kind of reduction step chosen from the low bits of the running values
  typedef enum logic [1:0] {
    OP_QUARTER = 2'd0,  // a divisible by 4
    OP_HALF    = 2'd1,  // a even, not divisible by 4
    OP_SUM     = 2'd2,  // a odd, a+b divisible by 4
    OP_DIFF    = 2'd3   // a odd, a-b divisible by 4
  } pmdiv_op_e;

endpackage

// File: rtl/pmdiv_aunit.sv
module pmdiv_aunit
  import pmdiv_pkg::*;
#(
  parameter int K = 192
) (
  input  logic signed [K:0] a_i,
  input  logic signed [K:0] b_i,
  output pmdiv_op_e         op_o,
  output logic signed [K:0] a_o
);

  logic signed [K+1:0] sum_w;
  logic signed [K+1:0] diff_w;
  logic signed [K+1:0] pick_w;
  logic signed [K+1:0] shr_w;

  assign sum_w  = {a_i[K], a_i} + {b_i[K], b_i};
  assign diff_w = {a_i[K], a_i} - {b_i[K], b_i};

  always_comb begin
    if (a_i[1:0] == 2'b00) begin
      op_o = OP_QUARTER;
    end else if (!a_i[0]) begin
      op_o = OP_HALF;
    end else if (a_i[1] ^ b_i[1]) begin
      op_o = OP_SUM;
    end else begin
      op_o = OP_DIFF;
    end
  end

  always_comb begin
    case (op_o)
      OP_SUM:  pick_w = sum_w;
      OP_DIFF: pick_w = diff_w;
      default: pick_w = {a_i[K], a_i};
    endcase
    if (op_o == OP_HALF) begin
      shr_w = pick_w >>> 1;
    end else begin
      shr_w = pick_w >>> 2;
    end
  end

  assign a_o = shr_w[K:0];

endmodule

// File: rtl/pmdiv_redc.sv
module pmdiv_redc #(
  parameter int K = 192
) (
  input  logic signed [K+2:0] val_i,
  input  logic [K-1:0]        p_i,
  input  logic                quarter_i,
  output logic signed [K:0]   res_o
);

  logic signed [K+2:0] pw;
  logic signed [K+2:0] corr_w;
  logic signed [K+2:0] tot_w;
  logic signed [K+2:0] shr_w;

  assign pw = {3'b000, p_i};

  // Add a multiple of p that makes the value divisible by 2 or 4
  always_comb begin
    if (quarter_i) begin
      case (val_i[1:0])
        2'b00:   corr_w = '0;
        2'b10:   corr_w = pw <<< 1;
        2'b01:   corr_w = p_i[1] ? pw : -pw;
        default: corr_w = p_i[1] ? -pw : pw;
      endcase
    end else begin
      corr_w = val_i[0] ? pw : '0;
    end
  end

  assign tot_w = val_i + corr_w;

  always_comb begin
    if (quarter_i) begin
      shr_w = tot_w >>> 2;
    end else begin
      shr_w = tot_w >>> 1;
    end
  end

  assign res_o = shr_w[K:0];

endmodule

// File: rtl/pmdiv_bounds.sv
module pmdiv_bounds
  import pmdiv_pkg::*;
#(
  parameter int K  = 192,
  parameter int BW = $clog2(K + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  pmdiv_op_e     op_i,
  output logic          swap_o,
  output logic [BW-1:0] alpha_o
);

  localparam logic [BW-1:0] KINIT = BW'(K);

  logic [BW-1:0] alpha_q, alpha_d;
  logic [BW-1:0] beta_q,  beta_d;
  logic signed [BW:0] dif_w;
  logic en_w;

  assign dif_w  = $signed({1'b0, alpha_q}) - $signed({1'b0, beta_q});
  assign swap_o = dif_w[BW];
  assign en_w   = load_i | step_i;

  always_comb begin
    alpha_d = alpha_q;
    beta_d  = beta_q;
    if (load_i) begin
      alpha_d = KINIT;
      beta_d  = KINIT;
    end else if (step_i) begin
      case (op_i)
        OP_QUARTER: alpha_d = alpha_q - BW'(2);
        OP_HALF:    alpha_d = alpha_q - BW'(1);
        default: begin
          if (swap_o) begin
            alpha_d = beta_q - BW'(1);
            beta_d  = alpha_q;
          end else begin
            alpha_d = alpha_q - BW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alpha_q <= '0;
      beta_q  <= '0;
    end else if (en_w) begin
      alpha_q <= alpha_d;
      beta_q  <= beta_d;
    end
  end

  assign alpha_o = alpha_q;

  // R4: the bounds never wrap below zero, which is what caps the step count
  a_r4_quarter_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OP_QUARTER) |-> alpha_q >= BW'(2));
  a_r4_half_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OP_HALF) |-> alpha_q >= BW'(1));
  a_r4_odd_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (op_i == OP_SUM || op_i == OP_DIFF)) |-> (alpha_q >= BW'(1) && beta_q >= BW'(1)));

endmodule

// File: rtl/pm_moddiv.sv
module pm_moddiv
  import pmdiv_pkg::*;
#(
  parameter int K = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [K-1:0] x_i,
  input  logic [K-1:0] y_i,
  input  logic [K-1:0] p_i,
  output logic [K-1:0] z_o,
  output logic         done_o
);

  localparam int BW = $clog2(K + 1);
  localparam int CW = $clog2(2 * K + 2) + 1;

  pmdiv_state_e state_q, state_d;
  logic signed [K:0] a_q, a_d, b_q, b_d, c_q, c_d, d_q, d_d;
  logic [K-1:0] p_q, z_q, z_d;
  logic done_q, done_d;
  logic [CW-1:0] run_cnt_q;

  logic load_w, step_w, fin_w, a_zero_w, odd_w, swap_w;
  pmdiv_op_e op_w;
  logic signed [K:0] a_step_w, c_step_w;
  logic signed [K+2:0] cx_w, dx_w, red_in_w;
  logic [BW-1:0] alpha_w;
  logic signed [K:0] zs_w, zf_w;

  assign a_zero_w = (a_q == '0);
  assign odd_w    = (op_w == OP_SUM) || (op_w == OP_DIFF);

  pmdiv_aunit #(.K(K)) u_aunit (
    .a_i  (a_q),
    .b_i  (b_q),
    .op_o (op_w),
    .a_o  (a_step_w)
  );

  assign cx_w = {{2{c_q[K]}}, c_q};
  assign dx_w = {{2{d_q[K]}}, d_q};

  always_comb begin
    case (op_w)
      OP_SUM:  red_in_w = cx_w + dx_w;
      OP_DIFF: red_in_w = cx_w - dx_w;
      default: red_in_w = cx_w;
    endcase
  end

  pmdiv_redc #(.K(K)) u_redc (
    .val_i     (red_in_w),
    .p_i       (p_q),
    .quarter_i (op_w != OP_HALF),
    .res_o     (c_step_w)
  );

  pmdiv_bounds #(.K(K), .BW(BW)) u_bounds (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .step_i  (step_w),
    .op_i    (op_w),
    .swap_o  (swap_w),
    .alpha_o (alpha_w)
  );

  // Sign fix-up: b ends at +1 or -1, so z is d or -d, lifted into [0, p)
  assign zs_w = b_q[K] ? -d_q : d_q;
  assign zf_w = zs_w[K] ? (zs_w + {1'b0, p_q}) : zs_w;

  always_comb begin
    state_d = state_q;
    a_d     = a_q;
    b_d     = b_q;
    c_d     = c_q;
    d_d     = d_q;
    load_w  = 1'b0;
    step_w  = 1'b0;
    fin_w   = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          load_w  = 1'b1;
          state_d = ST_RUN;
          a_d     = {1'b0, y_i};
          b_d     = {1'b0, p_i};
          c_d     = {1'b0, x_i};
          d_d     = '0;
        end
      end
      ST_RUN: begin
        if (a_zero_w) begin
          fin_w   = 1'b1;
          state_d = ST_DONE;
        end else begin
          step_w = 1'b1;
          a_d    = a_step_w;
          c_d    = c_step_w;
          if (odd_w && swap_w) begin
            b_d = a_q;
            d_d = c_q;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d = done_q;
    z_d    = z_q;
    if (load_w) begin
      done_d = 1'b0;
    end else if (fin_w) begin
      done_d = 1'b1;
      z_d    = zf_w[K-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      d_q <= '0;
    end else if (load_w || step_w) begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
      d_q <= d_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
    end else if (load_w) begin
      p_q <= p_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      z_q    <= '0;
    end else if (load_w || fin_w) begin
      done_q <= done_d;
      z_q    <= z_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt_q <= '0;
    end else if (load_w) begin
      run_cnt_q <= '0;
    end else if (state_q == ST_RUN) begin
      run_cnt_q <= run_cnt_q + CW'(1);
    end
  end

  assign z_o    = z_q;
  assign done_o = done_q;

  // R3: a stays inside its logarithmic bound, |a| < 2^alpha
  a_r3_a_within_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (((a_q[K] ? -a_q : a_q) >> alpha_w) == '0));
  // R3: c and d stay strictly between -p and p
  a_r3_cd_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (c_q > -$signed({1'b0, p_q}) && c_q < $signed({1'b0, p_q}) &&
                            d_q > -$signed({1'b0, p_q}) && d_q < $signed({1'b0, p_q})));
  // R3: b remains odd, and it is a unit when a reaches zero
  a_r3_b_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> b_q[0]);
  a_r3_b_unit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && a_zero_w) |-> (b_q == 1 || b_q == -1));
  // R4: step count bounded by 2K
  a_r4_iter_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> run_cnt_q <= CW'(2 * K));
  // R2: an accepted start clears done
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q != ST_RUN) |=> !done_o);
  // R5: start while running keeps the run going
  a_r5_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ST_RUN && !a_zero_w) |=> (state_q == ST_RUN && $stable(p_q)));
  // R7: result holds until the next start
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(z_o)));

endmodule

// File: tb/pm_moddiv_tb_top.sv
module pm_moddiv_tb_top;

  localparam int K   = 192;
  localparam int LIM = 2 * K + 1;
  localparam logic [K-1:0] P192 = {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF};

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [K-1:0] x, y, p;
  logic [K-1:0] z;
  logic done;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pm_moddiv #(.K(K)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .x_i     (x),
    .y_i     (y),
    .p_i     (p),
    .z_o     (z),
    .done_o  (done)
  );

  task automatic check(input string req, input bit ok, input logic [K-1:0] act, input logic [K-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit congruent(input logic [K-1:0] zz, input logic [K-1:0] yy,
                                   input logic [K-1:0] xx, input logic [K-1:0] pp);
    logic [2*K-1:0] prod;
    prod = {{K{1'b0}}, zz} * {{K{1'b0}}, yy};
    return (zz < pp) && ((prod % {{K{1'b0}}, pp}) == {{K{1'b0}}, xx});
  endfunction

  function automatic logic [K-1:0] rnd_below(input logic [K-1:0] pp);
    logic [K-1:0] r;
    r = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    return r % pp;
  endfunction

  // Runs one division and returns the result and the falling edges waited
  task automatic run_div(input logic [K-1:0] xx, input logic [K-1:0] yy, input logic [K-1:0] pp,
                         output logic [K-1:0] zz, output int cyc);
    @(negedge clk);
    x = xx; y = yy; p = pp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 done low after start", done == 1'b0, {{(K-1){1'b0}}, done}, '0);
    cyc = 0;
    while (!done && cyc <= LIM) begin
      @(negedge clk);
      cyc++;
    end
    zz = z;
    check("R4 latency", done && cyc <= LIM, K'(cyc), K'(LIM));
  endtask

  task automatic t_reset();
    check("R1 done after reset", done == 1'b0, {{(K-1){1'b0}}, done}, '0);
    check("R1 z after reset", z == '0, z, '0);
  endtask

  task automatic t_random(input logic [K-1:0] pp, input int n, input string req);
    logic [K-1:0] xx, yy, zz;
    int cyc;
    for (int i = 0; i < n; i++) begin
      xx = rnd_below(pp);
      yy = rnd_below(pp);
      if (yy == '0) yy = 1;
      run_div(xx, yy, pp, zz, cyc);
      check(req, congruent(zz, yy, xx, pp), zz, xx);
    end
  endtask

  task automatic t_special(input logic [K-1:0] pp);
    logic [K-1:0] xx, zz;
    int cyc;
    xx = rnd_below(pp);
    run_div(xx, 1, pp, zz, cyc);
    check("R6 y=1", zz == xx, zz, xx);
    run_div(xx, pp - 1, pp, zz, cyc);
    check("R6 y=p-1", zz == ((pp - xx) % pp), zz, (pp - xx) % pp);
    run_div('0, rnd_below(pp - 1) + 1, pp, zz, cyc);
    check("R6 x=0", zz == '0, zz, '0);
    run_div(pp - 1, 1, pp, zz, cyc);
    check("R6 x=p-1 y=1", zz == pp - 1, zz, pp - 1);
  endtask

  task automatic t_busy();
    logic [K-1:0] x1, y1, zz;
    int cyc;
    x1 = rnd_below(P192);
    y1 = rnd_below(P192) | 1;
    @(negedge clk);
    x = x1; y = y1; p = P192; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    x = x1 ^ 192'h5A5; y = y1 + 2; p = 192'd13; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5 still busy", done == 1'b0, {{(K-1){1'b0}}, done}, '0);
    cyc = 0;
    while (!done && cyc <= LIM) begin
      @(negedge clk);
      cyc++;
    end
    zz = z;
    check("R5 first result kept", done && congruent(zz, y1, x1, P192), zz, x1);
    repeat (10) @(negedge clk);
    check("R7 done held", done == 1'b1, {{(K-1){1'b0}}, done}, 1);
    check("R7 z held", z == zz, z, zz);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    x = '0; y = '0; p = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_special(192'd7);
    t_special(192'd65521);
    t_special(P192);
    t_random(192'd3, 4, "R3 p=3");
    t_random(192'd13, 6, "R3 p=13");
    t_random(192'd251, 6, "R3 p=251");
    t_random(192'd2147483647, 6, "R3 p=2^31-1");
    t_random(P192, 8, "R8 192-bit prime");
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule